// File: doc/BRIEF.md
# Flash Page Write Controller

This block sits between a processor and an embedded flash array. The processor fills a page staging buffer one byte at a time with table writes. The byte lane is chosen by the low address bits. The buffer itself never reaches the array. To commit the buffer, the processor must first write a two-byte unlock key to a key register. It must then immediately write the control register with both the start bit and the write-enable bit set. The controller then runs a long programming cycle. During that cycle it holds a stall output to the processor, copies the page (or a single 2-byte word in word mode) into the array, and ends the cycle only when its internal programming timer runs out.

The staging buffer keeps its contents after a commit. A later commit to another page reuses the bytes that were not overwritten. The array model keeps one "programmed" bit per byte. Programming a byte whose bit is already set raises a sticky error flag. An erase notification clears those bits for one 1024-byte erase block. The processor reads the array through a plain combinational read port.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `stall`, `done` and `prog_err` are 0 and `ctl_rd` reads 0x00.
- R2: A table write (`tbl_wr`) stores `tbl_data` into staging byte `tbl_addr[5:0]` and leaves the array contents unchanged. The last table-write address, excluding bit 0, becomes the commit pointer.
- R3: A commit starts only when three register writes arrive in this order with no other register write between them: 0x55 to the key register (`reg_sel`=1), then 0xAA to the key register, then a control write (`reg_sel`=0) with bit 0 (start) and bit 1 (write enable) both set. A control write with write enable clear starts nothing.
- R4: Any register write that is not the next expected key byte returns the unlock sequence to its initial state. A start request that does not follow a complete unlock is ignored, and `stall` stays 0.
- R5: In page mode (control bit 2 = 0), the commit copies all 64 staging bytes to the 64-byte page chosen by pointer bits [10:6]. Staging byte i goes to page offset i.
- R6: In word mode (control bit 2 = 1), only staging bytes {ptr[5:1],0} and {ptr[5:1],1} are copied, to the aligned word at the pointer. All other array bytes are left untouched.
- R7: `stall` and `ctl_rd` bit 0 (busy) rise on the clock edge that accepts the start and stay high for exactly PROG_CYCLES (80) cycles in both modes. In the cycle after they fall, `done` is high for exactly one cycle. Afterwards `ctl_rd` bit 0 reads 0.
- R8: The staging buffer is not cleared by a commit. A later commit programs the bytes left from earlier table writes.
- R9: While busy, table writes, key writes and control writes are ignored. They change neither the staging buffer nor the unlock state.
- R10: When a commit programs a byte that has already been programmed since the last erase of its block, `prog_err` becomes 1. It stays 1 until the next accepted start clears it.
- R11: An `erase_req` pulse clears the programmed tracking of the 1024-byte block `erase_blk` only. Bytes of other blocks still raise `prog_err` when programmed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr | input | 1 | Table write strobe into the staging buffer |
| tbl_addr | input | ADDR_W | Table write byte address |
| tbl_data | input | 8 | Table write data byte |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = key register |
| reg_wdata | input | 8 | Register write data |
| erase_req | input | 1 | Erase notification pulse |
| erase_blk | input | ADDR_W-10 | Index of the erased 1024-byte block |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |
| ctl_rd | output | 8 | Control readback: bit0 busy, bit1 write enable, bit2 word mode |
| stall | output | 1 | Processor stall during a long write |
| done | output | 1 | One-cycle pulse after a long write ends |
| prog_err | output | 1 | Sticky double-program error |

## Verification
The hardest state to reach from the ports is a burst of table, key and control traffic that lands while a long write is in progress. If any of it leaked through, the damage would only show up in a later commit. The bench loads a page, starts a commit, and during the stall issues a table write to a staged byte together with a complete key-and-start sequence. After `done`, it tries a start with no fresh key and expects nothing to happen. It then moves the pointer to a fresh page and commits. The array bytes show whether the buffer survived the stall untouched. The double-program flag is reached by committing the same page twice, and the erase scoping is checked by programming pages in two different erase blocks.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

   typedef enum logic [1:0] {
      KEY_WAIT_FIRST  = 2'd0,
      KEY_WAIT_SECOND = 2'd1,
      KEY_ARMED       = 2'd2
   } key_state_t;

   localparam int CTL_GO   = 0;
   localparam int CTL_WREN = 1;
   localparam int CTL_WORD = 2;

   localparam logic REG_SEL_CTL = 1'b0;
   localparam logic REG_SEL_KEY = 1'b1;

endpackage

// File: rtl/fpw_unlock.sv
module fpw_unlock
   import fpw_pkg::*;
#(
   parameter logic [7:0] KEY_FIRST  = 8'h55,
   parameter logic [7:0] KEY_SECOND = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       sel,
   input  logic [7:0] wdata,
   output logic       armed
);

   key_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (wr) begin
         case (st_q)
            KEY_WAIT_FIRST:
               st_d = (sel == REG_SEL_KEY && wdata == KEY_FIRST)
                      ? KEY_WAIT_SECOND : KEY_WAIT_FIRST;
            KEY_WAIT_SECOND:
               st_d = (sel == REG_SEL_KEY && wdata == KEY_SECOND)
                      ? KEY_ARMED : KEY_WAIT_FIRST;
            default:
               st_d = KEY_WAIT_FIRST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_WAIT_FIRST;
      else        st_q <= st_d;
   end

   assign armed = (st_q == KEY_ARMED);

   // R3: arming only follows the second key byte
   p_arm_on_second_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(wr && sel == REG_SEL_KEY && wdata == KEY_SECOND));

   // R4: any register write consumes an armed state
   p_arm_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr) |=> !armed);

endmodule

// File: rtl/fpw_holding.sv
module fpw_holding #(
   parameter int PAGE_BYTES = 64,
   localparam int IDX_W = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);

   logic [7:0] lane_q [PAGE_BYTES];

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[g] <= 8'h00;
         else if (wr_en && wr_idx == IDX_W'(g))
            lane_q[g] <= wr_data;
      end
   end

   assign rd_data = lane_q[rd_idx];

endmodule

// File: rtl/fpw_array.sv
module fpw_array #(
   parameter int ADDR_W      = 11,
   parameter int ERASE_BYTES = 1024,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int EB_W  = $clog2(ERASE_BYTES),
   localparam int BLK_W = ADDR_W - EB_W,
   localparam int NBLK  = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   output logic              already,
   input  logic              er_req,
   input  logic [BLK_W-1:0]  er_blk,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   logic [7:0]       cell_q [DEPTH];
   logic [DEPTH-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
      end else if (we) begin
         cell_q[waddr] <= wdata;
      end
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            used_q[b*ERASE_BYTES +: ERASE_BYTES] <= '0;
         else if (er_req && er_blk == BLK_W'(b))
            used_q[b*ERASE_BYTES +: ERASE_BYTES] <= '0;
         else if (we && waddr[ADDR_W-1:EB_W] == BLK_W'(b))
            used_q[waddr] <= 1'b1;
      end
   end

   assign already = used_q[waddr];
   assign rd_data = cell_q[rd_addr];

   // R11: erase and program never collide in one cycle
   p_no_erase_during_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && er_req));

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
   import fpw_pkg::*;
#(
   parameter int         ADDR_W       = 11,
   parameter int         PAGE_BYTES   = 64,
   parameter int         ERASE_BYTES  = 1024,
   parameter int         PROG_CYCLES  = 80,
   parameter bit         WORD_MODE_EN = 1'b1,
   parameter logic [7:0] KEY_FIRST    = 8'h55,
   parameter logic [7:0] KEY_SECOND   = 8'hAA,
   localparam int IDX_W = $clog2(PAGE_BYTES),
   localparam int EB_W  = $clog2(ERASE_BYTES),
   localparam int BLK_W = ADDR_W - EB_W,
   localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [7:0]        tbl_data,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              erase_req,
   input  logic [BLK_W-1:0]  erase_blk,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [7:0]        ctl_rd,
   output logic              stall,
   output logic              done,
   output logic              prog_err
);

   if ((1 << IDX_W) != PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if ((1 << EB_W) != ERASE_BYTES || ERASE_BYTES < PAGE_BYTES) begin : g_bad_erase
      $error("ERASE_BYTES must be a power of two not below PAGE_BYTES");
   end
   if (BLK_W < 1) begin : g_bad_addr
      $error("ADDR_W must cover more than one erase block");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_timer
      $error("PROG_CYCLES must be at least PAGE_BYTES");
   end

   logic                busy_q, done_q, err_q, word_q, wren_q;
   logic [ADDR_W-2:0]   ptr_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                armed, reg_ok, ctl_wr, start;
   logic                commit_we, already, timer_end;
   logic [IDX_W-1:0]    commit_idx;
   logic [ADDR_W-1:0]   commit_addr;
   logic [7:0]          commit_byte;
   logic [CNT_W-1:0]    commit_cnt;
   logic                word_req;

   assign reg_ok = reg_wr && !busy_q;
   assign ctl_wr = reg_ok && reg_sel == REG_SEL_CTL;
   assign start  = ctl_wr && armed && reg_wdata[CTL_GO] && reg_wdata[CTL_WREN];

   if (WORD_MODE_EN) begin : g_word
      assign word_req   = reg_wdata[CTL_WORD];
      assign commit_cnt = word_q ? CNT_W'(2) : CNT_W'(PAGE_BYTES);
      assign commit_idx = word_q ? {ptr_q[IDX_W-2:0], cnt_q[0]} : cnt_q[IDX_W-1:0];
   end else begin : g_page_only
      assign word_req   = 1'b0;
      assign commit_cnt = CNT_W'(PAGE_BYTES);
      assign commit_idx = cnt_q[IDX_W-1:0];
   end

   assign commit_we   = busy_q && cnt_q < commit_cnt;
   assign commit_addr = {ptr_q[ADDR_W-2:IDX_W-1], commit_idx};
   assign timer_end   = busy_q && cnt_q == CNT_W'(PROG_CYCLES - 1);

   fpw_unlock #(
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) i_unlock (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_ok),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .armed (armed)
   );

   fpw_holding #(
      .PAGE_BYTES (PAGE_BYTES)
   ) i_holding (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr && !busy_q),
      .wr_idx  (tbl_addr[IDX_W-1:0]),
      .wr_data (tbl_data),
      .rd_idx  (commit_idx),
      .rd_data (commit_byte)
   );

   fpw_array #(
      .ADDR_W      (ADDR_W),
      .ERASE_BYTES (ERASE_BYTES)
   ) i_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (commit_we),
      .waddr   (commit_addr),
      .wdata   (commit_byte),
      .already (already),
      .er_req  (erase_req && !busy_q),
      .er_blk  (erase_blk),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (tbl_wr && !busy_q) begin
         ptr_q <= tbl_addr[ADDR_W-1:1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wren_q <= 1'b0;
         word_q <= 1'b0;
      end else if (ctl_wr) begin
         wren_q <= reg_wdata[CTL_WREN];
         word_q <= word_req;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (commit_we && already) err_q <= 1'b1;
            if (timer_end) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign ctl_rd   = {5'b0, word_q, wren_q, busy_q};
   assign stall    = busy_q;
   assign done     = done_q;
   assign prog_err = err_q;

   // stall run length monitor for R7
   logic [CNT_W:0] stall_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stall_run <= '0;
      else if (stall)    stall_run <= stall_run + 1'b1;
      else               stall_run <= '0;
   end

   p_stall_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_run <= (CNT_W+1)'(PROG_CYCLES));

   p_done_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> done);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_keyed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> $past(armed));

   p_err_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> !prog_err);

   p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && $past(stall)) |-> $stable(ptr_q));

endmodule

// File: tb/test_flash_page_writer.sv
module test_flash_page_writer;

   localparam int ADDR_W = 11;
   localparam int PROG   = 80;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tbl_wr = 1'b0;
   logic [ADDR_W-1:0] tbl_addr = '0;
   logic [7:0]        tbl_data = '0;
   logic              reg_wr = 1'b0;
   logic              reg_sel = 1'b0;
   logic [7:0]        reg_wdata = '0;
   logic              erase_req = 1'b0;
   logic [0:0]        erase_blk = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data, ctl_rd;
   logic              stall, done, prog_err;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_buf [64];
   logic [7:0] exp_mem [2048];

   always #2.5 clk = ~clk;

   flash_page_writer i_flash_page_writer (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .erase_req(erase_req), .erase_blk(erase_blk),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ctl_rd(ctl_rd), .stall(stall), .done(done), .prog_err(prog_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tbl_write(input int addr, input logic [7:0] d);
      @(negedge clk);
      tbl_wr = 1'b1; tbl_addr = ADDR_W'(addr); tbl_data = d;
      @(negedge clk);
      tbl_wr = 1'b0;
      if (!stall) exp_buf[addr % 64] = d;
   endtask

   task automatic reg_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic keyed_start(input logic [7:0] ctl);
      reg_write(1'b1, 8'h55);
      reg_write(1'b1, 8'hAA);
      reg_write(1'b0, ctl);
   endtask

   // counts stall cycles from now on, then checks the done pulse
   task automatic wait_done(input string req, input int exp_len);
      int n = 0;
      while (stall && n < 1000) begin
         n++;
         @(negedge clk);
      end
      if (exp_len > 0) chk(n == exp_len, req, n, exp_len);
      chk(done == 1'b1, req, done, 1);
      @(negedge clk);
      chk(done == 1'b0, req, done, 0);
      chk(ctl_rd[0] == 1'b0, req, ctl_rd, 0);
   endtask

   task automatic model_page(input int base);
      for (int i = 0; i < 64; i++) exp_mem[base + i] = exp_buf[i];
   endtask

   task automatic check_range(input string req, input int lo, input int hi);
      bit ok = 1'b1;
      int bad_a = 0;
      int bad_v = 0;
      for (int a = lo; a <= hi; a++) begin
         rd_addr = ADDR_W'(a);
         #0.1;
         if (ok && rd_data !== exp_mem[a]) begin
            ok = 1'b0; bad_a = a; bad_v = int'(rd_data);
         end
      end
      chk(ok, req, bad_v, ok ? 0 : int'(exp_mem[bad_a]));
   endtask

   task automatic t_reset;
      chk(stall == 1'b0 && done == 1'b0, "R1", {stall, done}, 0);
      chk(prog_err == 1'b0, "R1", prog_err, 0);
      chk(ctl_rd == 8'h00, "R1", ctl_rd, 0);
   endtask

   task automatic t_load;
      for (int i = 0; i < 64; i++) tbl_write(12'h080 + i, 8'(i) ^ 8'h3C);
      check_range("R2", 12'h080, 12'h0BF);
   endtask

   task automatic t_bad_unlock;
      reg_write(1'b1, 8'h55); reg_write(1'b1, 8'h00);
      reg_write(1'b1, 8'hAA); reg_write(1'b0, 8'h03);
      chk(stall == 1'b0, "R4 wrong key", stall, 0);
      reg_write(1'b1, 8'hAA); reg_write(1'b1, 8'h55); reg_write(1'b0, 8'h03);
      chk(stall == 1'b0, "R4 swapped keys", stall, 0);
      reg_write(1'b1, 8'h55); reg_write(1'b0, 8'h02);
      reg_write(1'b1, 8'hAA); reg_write(1'b0, 8'h03);
      chk(stall == 1'b0, "R4 interleaved write", stall, 0);
      keyed_start(8'h01);
      chk(stall == 1'b0, "R3 wren clear", stall, 0);
      check_range("R3", 12'h080, 12'h0BF);
   endtask

   task automatic t_page;
      keyed_start(8'h03);
      chk(stall == 1'b1 && ctl_rd[0] == 1'b1, "R7 stall rises", ctl_rd, 1);
      wait_done("R7", PROG);
      model_page(12'h080);
      check_range("R5", 12'h07F, 12'h0C0);
   endtask

   task automatic t_word;
      tbl_write(12'h104, 8'hA1);
      tbl_write(12'h105, 8'hB2);
      keyed_start(8'h07);
      chk(ctl_rd[2] == 1'b1, "R6 mode readback", ctl_rd, 8'h07);
      wait_done("R6 length", PROG);
      exp_mem[12'h104] = 8'hA1; exp_mem[12'h105] = 8'hB2;
      check_range("R6", 12'h100, 12'h13F);
   endtask

   task automatic t_retain;
      tbl_write(12'h200, 8'h77);
      keyed_start(8'h03);
      wait_done("R8 length", PROG);
      model_page(12'h200);
      check_range("R8", 12'h200, 12'h23F);
   endtask

   task automatic t_busy;
      logic [7:0] keep1;
      tbl_write(12'h0C0, 8'h11);
      keep1 = exp_buf[1];
      keyed_start(8'h03);
      tbl_write(12'h0C1, 8'hEE);
      keyed_start(8'h03);
      wait_done("R9", 0);
      model_page(12'h0C0);
      reg_write(1'b0, 8'h03);
      chk(stall == 1'b0, "R9 keys during busy", stall, 0);
      tbl_write(12'h300, exp_buf[0]);
      keyed_start(8'h03);
      wait_done("R9", PROG);
      model_page(12'h300);
      rd_addr = 12'h301; #0.1;
      chk(rd_data == keep1, "R9 buffer held", rd_data, keep1);
      check_range("R9", 12'h0C0, 12'h0FF);
   endtask

   task automatic t_double;
      tbl_write(12'h080, exp_buf[0]);
      keyed_start(8'h03);
      wait_done("R10", PROG);
      model_page(12'h080);
      chk(prog_err == 1'b1, "R10 set", prog_err, 1);
      tbl_write(12'h400, exp_buf[0]);
      keyed_start(8'h03);
      chk(prog_err == 1'b0, "R10 cleared at start", prog_err, 0);
      wait_done("R10", PROG);
      model_page(12'h400);
      chk(prog_err == 1'b0, "R10 fresh page", prog_err, 0);
   endtask

   task automatic t_erase;
      @(negedge clk); erase_req = 1'b1; erase_blk = 1'b0;
      @(negedge clk); erase_req = 1'b0;
      tbl_write(12'h080, exp_buf[0]);
      keyed_start(8'h03);
      wait_done("R11", PROG);
      model_page(12'h080);
      chk(prog_err == 1'b0, "R11 erased block", prog_err, 0);
      tbl_write(12'h400, exp_buf[0]);
      keyed_start(8'h03);
      wait_done("R11", PROG);
      chk(prog_err == 1'b1, "R11 other block kept", prog_err, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_buf[i] = 8'h00;
      for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_bad_unlock();
      t_page();
      t_word();
      t_retain();
      t_busy();
      t_double();
      t_erase();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule